// File: doc/BRIEF.md
# Translation Unit Configuration Register Wrapper

This block connects a processor's peripheral slot to an address translation unit. The slot gives it a 256-byte window, and the processor presents only the byte offset within that window. A write into the window loads one of six configuration registers: the zone protection word, the process identifier, the entry index for the second-level table, and three words of entry data (one low word and two high words). The outputs of these registers feed the translation unit directly.

Software loads an entry in a fixed order. It writes the index and the two high words first, then the low word. Writing the low word completes the entry. If the value of the low word changes, the wrapper raises the second-level write enable for exactly one cycle. In that cycle all four entry registers already hold the new values, so the translation unit sees the whole entry at once.

The peripheral read strobe drives both relocation enables (instruction and data) directly. The wrapper also passes the processor's user-mode bit through to the translation unit. On the return path, it places the no-access and guarded faults onto two external interrupt lines, and ORs the two translation miss flags into the core's instruction and data cache-miss inputs.

The commit sequencer has two states. ST_IDLE is the state out of reset. The transition idle-to-commit happens when a low-word write with changed data is accepted. The transition commit-to-commit happens when another such write is accepted in the commit cycle. The transition commit-to-idle happens when no such write is accepted.

Top module: `mmuw_cfg_wrap`

## Requirements
- R1: After reset, every configuration register output reads zero and `l2_wr_en` is low.
- R2: A write at offset 0 loads `zone_prot`, at offset 1 loads `proc_id` (data bits 7:0), at offset 2 loads `entry_idx` (data bits 5:0), at offset 3 loads `entry_lo`, at offset 4 loads `entry_hi_a`, and at offset 5 loads `entry_hi_b`. The new value appears after the next rising clock edge.
- R3: A write at any offset from 6 to 255 changes no register.
- R4: While `bus_wr` is low, no register changes, whatever appears on the offset and data buses.
- R5: `l2_wr_en` is high for the cycle after a clock edge that accepted an offset-3 write whose data differs from the held `entry_lo`. If such writes come back to back, `l2_wr_en` stays high for each of them.
- R6: An offset-3 write with data equal to the held `entry_lo`, or a write to any other offset, leaves `l2_wr_en` low in the following cycle.
- R7: `irel_en` and `drel_en` both equal `bus_rd` in the same cycle. `bus_rd` and `bus_wr` are never high together.
- R8: `user_mode` equals `cpu_user_bit` in the same cycle. This bit is bit 0 of the processor status, where 1 means user mode and 0 means supervisor mode.
- R9: `ext_irq[0]` equals `xl_noaccess` and `ext_irq[1]` equals `xl_guarded`. `core_imiss` is `core_imiss_raw` OR `xl_imiss`, and `core_dmiss` is `core_dmiss_raw` OR `xl_dmiss`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_off | input | 8 | Byte offset within the peripheral window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Peripheral write strobe |
| bus_rd | input | 1 | Peripheral read strobe, also the relocation enable |
| cpu_user_bit | input | 1 | Status bit 0, 1 means user mode |
| xl_noaccess | input | 1 | No-access fault from the translation unit |
| xl_guarded | input | 1 | Guarded fault from the translation unit |
| xl_imiss | input | 1 | Instruction translation miss |
| xl_dmiss | input | 1 | Data translation miss |
| core_imiss_raw | input | 1 | Core's own instruction cache miss |
| core_dmiss_raw | input | 1 | Core's own data cache miss |
| zone_prot | output | 32 | Zone protection register |
| proc_id | output | 8 | Process identifier register |
| entry_idx | output | 6 | Second-level entry index |
| entry_lo | output | 32 | Entry low word |
| entry_hi_a | output | 32 | Entry high word A |
| entry_hi_b | output | 32 | Entry high word B |
| l2_wr_en | output | 1 | Second-level table write enable |
| irel_en | output | 1 | Instruction relocation enable |
| drel_en | output | 1 | Data relocation enable |
| user_mode | output | 1 | User-mode flag to the translation unit |
| ext_irq | output | 2 | Fault interrupt lines |
| core_imiss | output | 1 | Merged instruction miss to the core |
| core_dmiss | output | 1 | Merged data miss to the core |

## Verification
The register file is tested with directed writes to each of the six offsets. These show whether the offset-to-register mapping and the truncation of the process identifier and index fields are correct. Writes at offsets 6 and 255, and cycles where only the read strobe or no strobe is active, show whether any stray update occurs.

The commit strobe is tested with an ordered entry load, a rewrite of the same low word, and back-to-back low-word writes with changed data. These patterns separate three behaviours: a strobe on every low-word write, a strobe only when the value changes, and a strobe that fails to repeat on consecutive writes.

A long seeded random mix of offsets, data values, read cycles and idle cycles checks every register against a model kept in the bench. Explicit combinations of the fault and miss inputs check the routing of the return path.

// File: rtl/mmuw_pkg.sv
package mmuw_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 8;
    localparam int PID_W  = 8;
    localparam int IDX_W  = 6;
    localparam int NREG   = 6;

    typedef enum logic [2:0] {
        OFF_ZONE = 3'd0,
        OFF_PID  = 3'd1,
        OFF_IDX  = 3'd2,
        OFF_LO   = 3'd3,
        OFF_HIA  = 3'd4,
        OFF_HIB  = 3'd5
    } reg_off_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } commit_st_e;

endpackage

// File: rtl/mmuw_decode.sv
module mmuw_decode #(
    parameter int OFF_W = 8,
    parameter int NREG  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [OFF_W-1:0] off,
    output logic [NREG-1:0]  sel
);

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g] = wr && (off == OFF_W'(g));
    end

    // At most one register is selected in any cycle (R2).
    a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // An offset outside the register bank selects nothing (R3).
    a_r3_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (off >= OFF_W'(NREG))) |-> (sel == '0));

endmodule

// File: rtl/mmuw_field.sv
module mmuw_field #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= d;
    end

    // A register changes only on a clock edge where it is selected (R4).
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));

endmodule

// File: rtl/mmuw_commit_fsm.sv
module mmuw_commit_fsm
    import mmuw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lo_sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] lo_q,
    output logic         l2_wr_en
);

    commit_st_e state, state_nx;
    logic       lo_wr_chg;

    assign lo_wr_chg = lo_sel && (wdata != lo_q);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (lo_wr_chg) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = lo_wr_chg ? ST_COMMIT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        l2_wr_en = 1'b0;
        unique case (state)
            ST_IDLE:   l2_wr_en = 1'b0;
            ST_COMMIT: l2_wr_en = 1'b1;
            default:   l2_wr_en = 1'b0;
        endcase
    end

    // A changed low-word write is followed by the enable (R5).
    a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_chg |=> l2_wr_en);

    // The enable appears only after a changed low-word write (R6).
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        l2_wr_en |-> $past(lo_wr_chg));

    // The low word holds its new value while the enable is high (R5).
    a_r5_lo_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_chg |=> (lo_q == $past(wdata)));

endmodule

// File: rtl/mmuw_cfg_wrap.sv
module mmuw_cfg_wrap
    import mmuw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              cpu_user_bit,
    input  logic              xl_noaccess,
    input  logic              xl_guarded,
    input  logic              xl_imiss,
    input  logic              xl_dmiss,
    input  logic              core_imiss_raw,
    input  logic              core_dmiss_raw,
    output logic [DATA_W-1:0] zone_prot,
    output logic [PID_W-1:0]  proc_id,
    output logic [IDX_W-1:0]  entry_idx,
    output logic [DATA_W-1:0] entry_lo,
    output logic [DATA_W-1:0] entry_hi_a,
    output logic [DATA_W-1:0] entry_hi_b,
    output logic              l2_wr_en,
    output logic              irel_en,
    output logic              drel_en,
    output logic              user_mode,
    output logic [1:0]        ext_irq,
    output logic              core_imiss,
    output logic              core_dmiss
);

    logic [NREG-1:0] sel;

    mmuw_decode #(.OFF_W(OFF_W), .NREG(NREG)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .off(bus_off), .sel(sel)
    );

    mmuw_field #(.W(DATA_W)) u_zone (
        .clk(clk), .rst_n(rst_n), .en(sel[OFF_ZONE]),
        .d(bus_wdata), .q(zone_prot)
    );

    mmuw_field #(.W(PID_W)) u_pid (
        .clk(clk), .rst_n(rst_n), .en(sel[OFF_PID]),
        .d(bus_wdata[PID_W-1:0]), .q(proc_id)
    );

    mmuw_field #(.W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .en(sel[OFF_IDX]),
        .d(bus_wdata[IDX_W-1:0]), .q(entry_idx)
    );

    mmuw_field #(.W(DATA_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .en(sel[OFF_LO]),
        .d(bus_wdata), .q(entry_lo)
    );

    mmuw_field #(.W(DATA_W)) u_hia (
        .clk(clk), .rst_n(rst_n), .en(sel[OFF_HIA]),
        .d(bus_wdata), .q(entry_hi_a)
    );

    mmuw_field #(.W(DATA_W)) u_hib (
        .clk(clk), .rst_n(rst_n), .en(sel[OFF_HIB]),
        .d(bus_wdata), .q(entry_hi_b)
    );

    mmuw_commit_fsm #(.W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .lo_sel(sel[OFF_LO]),
        .wdata(bus_wdata), .lo_q(entry_lo), .l2_wr_en(l2_wr_en)
    );

    always_comb begin
        irel_en    = bus_rd;
        drel_en    = bus_rd;
        user_mode  = cpu_user_bit;
        ext_irq    = {xl_guarded, xl_noaccess};
        core_imiss = core_imiss_raw | xl_imiss;
        core_dmiss = core_dmiss_raw | xl_dmiss;
    end

    // The peripheral strobes are mutually exclusive (R7).
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // No register moves during a read-only cycle (R4).
    a_r4_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> ($stable(entry_lo) && $stable(zone_prot) && !l2_wr_en));

endmodule

// File: tb/sim_mmuw_cfg_wrap.sv
module sim_mmuw_cfg_wrap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, cpu_user_bit = 1'b0;
    logic        xl_noaccess = 1'b0, xl_guarded = 1'b0, xl_imiss = 1'b0, xl_dmiss = 1'b0;
    logic        core_imiss_raw = 1'b0, core_dmiss_raw = 1'b0;
    logic [31:0] zone_prot, entry_lo, entry_hi_a, entry_hi_b;
    logic [7:0]  proc_id;
    logic [5:0]  entry_idx;
    logic        l2_wr_en, irel_en, drel_en, user_mode, core_imiss, core_dmiss;
    logic [1:0]  ext_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [6];

    always #4 clk = ~clk;

    mmuw_cfg_wrap u0 (.*);

    function automatic logic [31:0] fld_mask(int idx);
        if (idx == 1) return 32'h0000_00FF;
        if (idx == 2) return 32'h0000_003F;
        return 32'hFFFF_FFFF;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_regs(string req);
        chk(req, zone_prot, mdl[0]);
        chk(req, {24'h0, proc_id}, mdl[1]);
        chk(req, {26'h0, entry_idx}, mdl[2]);
        chk(req, entry_lo, mdl[3]);
        chk(req, entry_hi_a, mdl[4]);
        chk(req, entry_hi_b, mdl[5]);
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(logic wr, logic rd, logic [7:0] off, logic [31:0] d, string req);
        logic chg;
        bus_wr = wr; bus_rd = rd; bus_off = off; bus_wdata = d;
        #1;
        chk("R7", {30'h0, irel_en, drel_en}, {30'h0, rd, rd});
        chg = wr && (off == 8'd3) && (d != mdl[3]);
        if (wr && off < 8'd6) mdl[off] = d & fld_mask(int'(off));
        @(posedge clk); #2;
        chk_regs(req);
        chk(chg ? "R5" : "R6", {31'h0, l2_wr_en}, {31'h0, chg});
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 6; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        chk_regs("R1");
        chk("R1", {31'h0, l2_wr_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: ordered entry load, each offset once
        step(1, 0, 8'd2, 32'hFFFF_FFE5, "R2");
        step(1, 0, 8'd4, 32'hA5A5_0001, "R2");
        step(1, 0, 8'd5, 32'h5A5A_0002, "R2");
        step(1, 0, 8'd0, 32'h1234_5678, "R2");
        step(1, 0, 8'd1, 32'hCAFE_BE3C, "R2");
        step(1, 0, 8'd3, 32'hDEAD_0003, "R5");
        // R6: same low word again
        step(1, 0, 8'd3, 32'hDEAD_0003, "R6");
        // R5: back-to-back changed low words
        step(1, 0, 8'd3, 32'h0000_0010, "R5");
        step(1, 0, 8'd3, 32'h0000_0011, "R5");
        // R3: out-of-range offsets
        step(1, 0, 8'd6, 32'hFFFF_FFFF, "R3");
        step(1, 0, 8'd255, 32'hFFFF_FFFF, "R3");
        // R4: read-only and idle cycles with changing buses
        step(0, 1, 8'd3, 32'h7777_7777, "R4");
        step(0, 0, 8'd0, 32'h8888_8888, "R4");

        // R8 and R9: pass-through paths
        for (int v = 0; v < 64; v++) begin
            {cpu_user_bit, xl_noaccess, xl_guarded, xl_imiss, xl_dmiss, core_imiss_raw} = 6'(v);
            core_dmiss_raw = v[0] ^ v[3];
            #1;
            chk("R8", {31'h0, user_mode}, {31'h0, cpu_user_bit});
            chk("R9", {30'h0, ext_irq}, {30'h0, xl_guarded, xl_noaccess});
            chk("R9", {30'h0, core_imiss, core_dmiss},
                {30'h0, core_imiss_raw | xl_imiss, core_dmiss_raw | xl_dmiss});
        end
        @(negedge clk);

        // Random mix of writes, reads and idles (R2, R4, R5, R6)
        for (int n = 0; n < 600; n++) begin
            int kind;
            logic [7:0] off;
            logic [31:0] d;
            kind = int'($urandom_range(0, 9));
            off = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 6));
            d = ($urandom_range(0, 3) == 0) ? mdl[3] : $urandom;
            if (kind < 6)      step(1, 0, off, d, "R2");
            else if (kind < 8) step(0, 1, off, d, "R4");
            else               step(0, 0, off, d, "R4");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule